// File: doc/BRIEF.md
# NAND Two-Phase Access Sequencer

This block sits between a simple memory-mapped request port and an 8-bit NAND flash bus. Each request carries its whole meaning in its address: one address bit picks between a command phase and a data phase. Other fields hold the command bytes, the number of address cycles, whether a closing command follows, whether chip enable is dropped at the end, and which chip is targeted. The block turns one request into a sequence of strobed flash bus cycles and then gives a one-cycle response.

A command-phase request sends a start command with CLE high. It then sends up to seven address bytes with ALE high, taken from the request write data with the least significant byte first. A closing command can follow. A data-phase request moves one bus word of bytes, lowest byte first. It writes them with WE# pulses, or reads them with RE# pulses and returns them in the response. It can end with a closing command and can release chip enable. Every WE# and RE# pulse is two clocks low and two clocks high. After any closing command the block waits out a short guard interval. It then holds the response until R/B# reports ready.

Top module: `nand_seq`

## Requirements
- R1: Request address bit 19 selects the phase: 0 is a command-phase access and 1 is a data-phase access.
- R2: A command-phase access first drives the start command from address bits [10:3] with one WE# pulse, CLE high and ALE low.
- R3: In a command phase, address bits [23:21] give the number of address cycles (0 to 7) that follow the start command. Each cycle drives one byte with ALE high and CLE low. The bytes come from req_wdata, least significant first. Address cycles beyond the width of req_wdata drive 0x00.
- R4: When address bit 20 is set, a closing command from address bits [18:11] is driven with CLE high. It comes after the address cycles in a command phase, or after the last data byte in a data phase. When bit 20 is clear, no closing command is driven.
- R5: CE# of the addressed chip is low for the whole access and stays low after it. The exception is a data-phase access with address bit 21 set: then all CE# lines are high from the cycle after the response.
- R6: Each WE# or RE# pulse is exactly 2 clocks low, and consecutive pulses within an access start 4 clocks apart. WE# and RE# are never low together.
- R7: After a closing command, the block waits BUSY_GUARD clocks. After that it gives no response while nand_rb_n is low.
- R8: A data-phase read (req_write low) issues BUS_BYTES RE# pulses and keeps nand_io_oe low. The byte on nand_io_in at the end of pulse k goes to rsp_rdata bits [8k+7:8k].
- R9: A data-phase write drives the req_wdata bytes lowest first, one WE# pulse each, with CLE and ALE low. Address bit 10 and bits [9:3] and [2:0] have no effect on a data-phase access.
- R10: The chip is chosen by address bits [24 +: log2(NUM_CHIPS)]. Chip i drives CE# bit i low, and at most one CE# line is low at any time.
- R11: After reset, all CE# lines, WE# and RE# are high, CLE, ALE and nand_io_oe are low, and req_ready is high. req_ready is high only when the block is idle. A request is taken when req_valid and req_ready are both high. rsp_valid is high for exactly one cycle at the end of each access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | Data phase: 1 writes, 0 reads |
| req_addr | input | 32 | Encoded access address |
| req_wdata | input | 8*BUS_BYTES | Address bytes or write data |
| rsp_valid | output | 1 | Access finished (one cycle) |
| rsp_rdata | output | 8*BUS_BYTES | Bytes read in a data-phase read |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | NUM_CHIPS | Chip enables, active low |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Drive enable for nand_io_out |
| nand_io_in | input | 8 | Byte returned by the flash |
| nand_rb_n | input | 1 | Ready (high) or busy (low) |

## Verification
The bench targets the counted address cycles: zero cycles, one cycle, and five cycles, which runs past the width of the write word. A wrong count shows up as a missing or extra ALE byte, and wrong byte order shows up as swapped ALE bytes. The device pulls R/B# low only after the closing command. A design that sampled it too early, or ignored it, would answer while the device is still busy. The bench checks that a data access with the release bit set drops all chip enables while plain accesses keep them low, and that the upper chip-address bit moves chip enable to the second line. It also sets the ECC-last and reserved bits and confirms the bus sequence does not change. A read that assembled bytes in the wrong order, or drove the bus while reading, would return a scrambled word or break the drive-enable check.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD1,
        S_ADDR,
        S_DATA,
        S_CMD2,
        S_WAIT,
        S_DONE
    } seq_state_e;

    // Fields pulled out of the access address
    typedef struct packed {
        logic       data_phase;
        logic [7:0] first_cmd;
        logic [2:0] n_addr;
        logic       last_cmd_en;
        logic [7:0] last_cmd;
        logic       drop_ce;
        logic [7:0] chip;
    } acc_t;

endpackage

// File: rtl/nand_seq_decode.sv
module nand_seq_decode
    import nand_seq_pkg::*;
(
    input  logic [31:0] addr,
    output acc_t        acc
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^addr[2:0];

    always_comb begin
        acc.data_phase  = addr[19];
        acc.first_cmd   = addr[10:3];
        acc.n_addr      = addr[19] ? 3'd0 : addr[23:21];
        acc.last_cmd_en = addr[20];
        acc.last_cmd    = addr[18:11];
        acc.drop_ce     = addr[19] & addr[21];
        acc.chip        = addr[31:24];
    end
endmodule

// File: rtl/nand_seq_slot.sv
module nand_seq_slot #(
    parameter int LOW_CLKS  = 2,
    parameter int HIGH_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe_low,
    output logic capture,
    output logic slot_end
);
    localparam int SLOT = LOW_CLKS + HIGH_CLKS;
    localparam int PW   = $clog2(SLOT);

    logic [PW-1:0] ph_d, ph_q;

    always_comb begin
        strobe_low = run && (ph_q < PW'(LOW_CLKS));
        capture    = run && (ph_q == PW'(LOW_CLKS - 1));
        slot_end   = run && (ph_q == PW'(SLOT - 1));
        if (!run || slot_end) ph_d = '0;
        else                  ph_d = ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nand_seq_pkg::*;
#(
    parameter int NUM_CHIPS  = 2,
    parameter int BUS_BYTES  = 4,
    parameter int BUSY_GUARD = 4,
    parameter int PULSE_LOW  = 2,
    parameter int PULSE_HIGH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [31:0]            req_addr,
    input  logic [8*BUS_BYTES-1:0] req_wdata,
    output logic                   rsp_valid,
    output logic [8*BUS_BYTES-1:0] rsp_rdata,
    output logic                   nand_cle,
    output logic                   nand_ale,
    output logic                   nand_we_n,
    output logic                   nand_re_n,
    output logic [NUM_CHIPS-1:0]   nand_ce_n,
    output logic [7:0]             nand_io_out,
    output logic                   nand_io_oe,
    input  logic [7:0]             nand_io_in,
    input  logic                   nand_rb_n
);
    localparam int BUS_DW = 8 * BUS_BYTES;
    localparam int CHIP_W = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1;
    localparam int CNT_W  = $clog2((BUS_BYTES > 8) ? BUS_BYTES : 8);
    localparam int GW     = $clog2(BUSY_GUARD + 1);

    typedef struct packed {
        seq_state_e            st;
        logic                  rd;
        acc_t                  acc;
        logic [BUS_DW-1:0]     wd;
        logic [BUS_DW-1:0]     rdat;
        logic [CNT_W-1:0]      idx;
        logic [GW-1:0]         guard;
        logic [NUM_CHIPS-1:0]  ce_n;
    } regs_t;

    regs_t q, d;
    acc_t  acc_in;
    seq_state_e cur_st;
    logic  run, strobe_low, capture, slot_end, drives_bus;
    logic  last_addr, last_byte;
    logic [7:0] cur_byte;
    logic  unused_chip;

    assign cur_st      = q.st;
    assign unused_chip = ^acc_in.chip[7:CHIP_W];

    nand_seq_decode u_decode (
        .addr (req_addr),
        .acc  (acc_in)
    );

    nand_seq_slot #(
        .LOW_CLKS  (PULSE_LOW),
        .HIGH_CLKS (PULSE_HIGH)
    ) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .strobe_low (strobe_low),
        .capture    (capture),
        .slot_end   (slot_end)
    );

    always_comb begin
        run = (cur_st == S_CMD1) || (cur_st == S_ADDR) ||
              (cur_st == S_DATA) || (cur_st == S_CMD2);
        drives_bus = run && !((cur_st == S_DATA) && q.rd);
        last_addr  = (q.idx + 1'b1) == CNT_W'(q.acc.n_addr);
        last_byte  = q.idx == CNT_W'(BUS_BYTES - 1);
        cur_byte   = 8'h00;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (q.idx == CNT_W'(i)) cur_byte = q.wd[8*i +: 8];
        end
    end

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.acc  = acc_in;
                    d.rd   = !req_write;
                    d.wd   = req_wdata;
                    d.idx  = '0;
                    d.ce_n = ~(NUM_CHIPS'(1) << acc_in.chip[CHIP_W-1:0]);
                    if (acc_in.data_phase) begin
                        d.rdat = '0;
                        d.st   = S_DATA;
                    end else begin
                        d.st   = S_CMD1;
                    end
                end
            end
            S_CMD1: if (slot_end) begin
                if (q.acc.n_addr != 3'd0)  d.st = S_ADDR;
                else if (q.acc.last_cmd_en) d.st = S_CMD2;
                else                        d.st = S_DONE;
            end
            S_ADDR: if (slot_end) begin
                if (!last_addr)             d.idx = q.idx + 1'b1;
                else if (q.acc.last_cmd_en) d.st  = S_CMD2;
                else                        d.st  = S_DONE;
            end
            S_DATA: begin
                if (capture && q.rd) begin
                    for (int i = 0; i < BUS_BYTES; i++) begin
                        if (q.idx == CNT_W'(i)) d.rdat[8*i +: 8] = nand_io_in;
                    end
                end
                if (slot_end) begin
                    if (!last_byte)             d.idx = q.idx + 1'b1;
                    else if (q.acc.last_cmd_en) d.st  = S_CMD2;
                    else                        d.st  = S_DONE;
                end
            end
            S_CMD2: if (slot_end) begin
                d.guard = '0;
                d.st    = S_WAIT;
            end
            S_WAIT: begin
                if (q.guard < GW'(BUSY_GUARD)) d.guard = q.guard + 1'b1;
                else if (nand_rb_n)            d.st    = S_DONE;
            end
            S_DONE: begin
                if (q.acc.drop_ce) d.ce_n = '1;
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.ce_n <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready   = cur_st == S_IDLE;
        rsp_valid   = cur_st == S_DONE;
        rsp_rdata   = q.rdat;
        nand_cle    = (cur_st == S_CMD1) || (cur_st == S_CMD2);
        nand_ale    = cur_st == S_ADDR;
        nand_we_n   = !(strobe_low && drives_bus);
        nand_re_n   = !(strobe_low && (cur_st == S_DATA) && q.rd);
        nand_ce_n   = q.ce_n;
        nand_io_oe  = drives_bus;
        unique case (cur_st)
            S_CMD1:  nand_io_out = q.acc.first_cmd;
            S_CMD2:  nand_io_out = q.acc.last_cmd;
            S_ADDR:  nand_io_out = cur_byte;
            S_DATA:  nand_io_out = q.rd ? 8'h00 : cur_byte;
            default: nand_io_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk
    import nand_seq_pkg::*;
#(
    parameter int NUM_CHIPS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 nand_cle,
    input logic                 nand_ale,
    input logic                 nand_we_n,
    input logic                 nand_re_n,
    input logic [NUM_CHIPS-1:0] nand_ce_n,
    input logic                 nand_io_oe,
    input logic                 nand_rb_n,
    input seq_state_e           state
);
    // R6: strobes never overlap
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R6: WE# low for exactly two clocks
    assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |=> !nand_we_n ##1 nand_we_n);

    // R6: RE# low for exactly two clocks
    assert_re_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |=> !nand_re_n ##1 nand_re_n);

    // R8: bus not driven while reading
    assert_read_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_io_oe);

    // R2: command and address latches exclusive
    assert_cle_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R7: no progress while the flash is busy after the guard
    assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !nand_rb_n) |=> state == S_WAIT);

    // R5: chip enables hold while idle
    assert_ce_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(nand_ce_n));

    // R10: at most one chip enabled
    assert_ce_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~nand_ce_n));
endmodule

bind nand_seq nand_seq_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_ce_n  (nand_ce_n),
    .nand_io_oe (nand_io_oe),
    .nand_rb_n  (nand_rb_n),
    .state      (cur_st)
);

// File: tb/nand_seq_bench.sv
module nand_seq_bench;
    localparam int NC = 2;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [8*NB-1:0] req_wdata = '0, rsp_rdata;
    logic rsp_valid, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [NC-1:0] nand_ce_n;
    logic [7:0] nand_io_out;
    logic [7:0] nand_io_in = 8'h00;
    logic nand_rb_n = 1'b1;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    // flash bus log
    int log_n = 0;
    logic [1:0] log_kind [64];   // 2: CLE, 1: ALE, 0: data
    logic [7:0] log_byte [64];
    logic [NC-1:0] log_ce [64];
    int log_t [64];
    logic we_prev = 1'b1, re_prev = 1'b1, rb_prev = 1'b1;
    int we_low = 0, re_low = 0, bad_width = 0, rd_idx = 0;
    int busy_left = 0, rb_rise_cyc = 0, oe_during_re = 0;

    always #2 clk = ~clk;

    nand_seq u_nand_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_ce_n(nand_ce_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // flash model, sampled away from the active edge
    always @(negedge clk) begin
        if (!nand_we_n) we_low++;
        if (!nand_re_n) re_low++;
        if (!nand_re_n && nand_io_oe) oe_during_re++;
        if (we_prev == 1'b0 && nand_we_n == 1'b1) begin
            if (we_low != 2) bad_width++;
            we_low = 0;
            if (log_n < 64) begin
                log_kind[log_n] = nand_cle ? 2'd2 : (nand_ale ? 2'd1 : 2'd0);
                log_byte[log_n] = nand_io_out;
                log_ce[log_n]   = nand_ce_n;
                log_t[log_n]    = cyc;
                log_n++;
            end
            if (nand_cle && nand_io_out == 8'h30) busy_left = 20;
        end
        if (re_prev == 1'b0 && nand_re_n == 1'b1) begin
            if (re_low != 2) bad_width++;
            re_low = 0;
        end
        if (re_prev == 1'b1 && nand_re_n == 1'b0) begin
            nand_io_in = 8'h5A + 8'(8'h11 * rd_idx);
            rd_idx++;
        end
        if (busy_left > 0) begin
            nand_rb_n = 1'b0;
            busy_left--;
        end else begin
            nand_rb_n = 1'b1;
        end
        if (!rb_prev && nand_rb_n) rb_rise_cyc = cyc;
        we_prev = nand_we_n;
        re_prev = nand_re_n;
        rb_prev = nand_rb_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_log(input string req, input int i,
                           input logic [1:0] kind, input logic [7:0] b);
        chk(log_n > i, req, "log length", log_n, i + 1);
        if (log_n > i) begin
            chk(log_kind[i] == kind, req, $sformatf("entry %0d kind", i), log_kind[i], kind);
            chk(log_byte[i] == b, req, $sformatf("entry %0d byte", i), log_byte[i], b);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input logic [7:0] first, input int n,
                                           input bit endv, input logic [7:0] endc);
        return (32'(n) << 21) | (32'(endv) << 20) | (32'(endc) << 11) | (32'(first) << 3);
    endfunction

    function automatic logic [31:0] mk_dat(input bit endv, input logic [7:0] endc,
                                           input bit rel, input logic [7:0] chip);
        return (32'(chip) << 24) | (32'(rel) << 21) | (32'(endv) << 20) |
               (32'd1 << 19) | (32'(endc) << 11);
    endfunction

    int rsp_cyc;
    logic [8*NB-1:0] got_rdata;

    task automatic access(input bit wr, input logic [31:0] a, input logic [8*NB-1:0] wd);
        log_n = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        rsp_cyc = cyc;
        got_rdata = rsp_rdata;
        @(negedge clk);
        chk(!rsp_valid, "R11", "rsp_valid one cycle", rsp_valid, 0);
    endtask

    task automatic t_reset;
        chk(nand_ce_n == '1, "R11", "reset ce_n", nand_ce_n, 2'b11);
        chk(nand_we_n && nand_re_n, "R11", "reset strobes", {nand_we_n, nand_re_n}, 2'b11);
        chk(!nand_cle && !nand_ale && !nand_io_oe, "R11", "reset latches",
            {nand_cle, nand_ale, nand_io_oe}, 0);
        chk(req_ready && !rsp_valid, "R11", "reset handshake", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic t_cmd_one_addr;   // R1 R2 R3
        access(1'b0, mk_cmd(8'h90, 1, 1'b0, 8'h00), 32'h0000_00C7);
        chk(log_n == 2, "R1", "command phase cycles", log_n, 2);
        chk_log("R2", 0, 2'd2, 8'h90);
        chk_log("R3", 1, 2'd1, 8'hC7);
        chk(log_ce[0] == 2'b10, "R5", "ce chip0 during access", log_ce[0], 2'b10);
    endtask

    task automatic t_cmd_no_addr;    // R3 R4 zero count, no end
        access(1'b0, mk_cmd(8'hFF, 0, 1'b0, 8'h55), 32'hDEAD_BEEF);
        chk(log_n == 1, "R4", "only start command", log_n, 1);
        chk_log("R2", 0, 2'd2, 8'hFF);
    endtask

    task automatic t_cmd_five_busy;  // R3 R4 R7
        access(1'b0, mk_cmd(8'h00, 5, 1'b1, 8'h30), 32'h4433_2211);
        chk(log_n == 7, "R3", "five address cycles plus commands", log_n, 7);
        chk_log("R2", 0, 2'd2, 8'h00);
        chk_log("R3", 1, 2'd1, 8'h11);
        chk_log("R3", 2, 2'd1, 8'h22);
        chk_log("R3", 3, 2'd1, 8'h33);
        chk_log("R3", 4, 2'd1, 8'h44);
        chk_log("R3", 5, 2'd1, 8'h00);
        chk_log("R4", 6, 2'd2, 8'h30);
        chk(rsp_cyc > rb_rise_cyc && rb_rise_cyc > log_t[6], "R7",
            "response after ready", rsp_cyc, rb_rise_cyc);
    endtask

    task automatic t_guard;          // R7 device never busy
        access(1'b0, mk_cmd(8'h70, 0, 1'b1, 8'hE0), 32'h0);
        chk_log("R4", 1, 2'd2, 8'hE0);
        chk(rsp_cyc - log_t[1] >= 4, "R7", "guard before response",
            rsp_cyc - log_t[1], 4);
    endtask

    task automatic t_write;          // R9 R6 R5
        access(1'b1, mk_dat(1'b0, 8'h00, 1'b0, 8'h00), 32'hA1B2_C3D4);
        chk(log_n == 4, "R9", "write byte count", log_n, 4);
        chk_log("R9", 0, 2'd0, 8'hD4);
        chk_log("R9", 1, 2'd0, 8'hC3);
        chk_log("R9", 2, 2'd0, 8'hB2);
        chk_log("R9", 3, 2'd0, 8'hA1);
        chk(log_t[1] - log_t[0] == 4, "R6", "pulse period", log_t[1] - log_t[0], 4);
        chk(nand_ce_n == 2'b10, "R5", "ce kept after access", nand_ce_n, 2'b10);
    endtask

    task automatic t_read;           // R8
        rd_idx = 0;
        access(1'b0, mk_dat(1'b0, 8'h00, 1'b0, 8'h00), 32'h0);
        chk(log_n == 0, "R8", "no WE pulses in read", log_n, 0);
        chk(got_rdata == 32'h8D7C_6B5A, "R8", "read data order", got_rdata, 32'h8D7C_6B5A);
        chk(oe_during_re == 0, "R8", "bus not driven in read", oe_during_re, 0);
    endtask

    task automatic t_write_end;      // R4 end command after data
        access(1'b1, mk_dat(1'b1, 8'h10, 1'b0, 8'h00), 32'h0403_0201);
        chk(log_n == 5, "R4", "data then end command", log_n, 5);
        chk_log("R9", 0, 2'd0, 8'h01);
        chk_log("R4", 4, 2'd2, 8'h10);
    endtask

    task automatic t_ignored;        // R9 ECC-last and reserved bits
        access(1'b1, mk_dat(1'b0, 8'h00, 1'b0, 8'h00) | 32'h0000_07FF, 32'h1122_3344);
        chk(log_n == 4, "R9", "ignored bits count", log_n, 4);
        chk_log("R9", 0, 2'd0, 8'h44);
        chk_log("R9", 3, 2'd0, 8'h11);
        chk(nand_ce_n == 2'b10, "R9", "ignored bits keep ce", nand_ce_n, 2'b10);
    endtask

    task automatic t_chip_release;   // R10 R5
        access(1'b1, mk_dat(1'b0, 8'h00, 1'b1, 8'h01), 32'h0);
        chk(log_n == 4 && log_ce[0] == 2'b01, "R10", "chip1 ce during access",
            log_ce[0], 2'b01);
        chk(nand_ce_n == 2'b11, "R5", "ce released", nand_ce_n, 2'b11);
        @(negedge clk);
        chk(nand_ce_n == 2'b11, "R5", "ce stays released", nand_ce_n, 2'b11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_cmd_one_addr();
        t_cmd_no_addr();
        t_cmd_five_busy();
        t_guard();
        t_write();
        t_read();
        t_write_end();
        t_ignored();
        t_chip_release();
        chk(bad_width == 0, "R6", "strobe low width", bad_width, 0);
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule